// File: doc/BRIEF.md
# GPIO Interrupt Detector and Aggregator

This block turns the already-filtered levels of a bank of GPIO pins into interrupt events. Each pin has its own trigger setup: edge or level detection, and a polarity of low, high or both edges. Each pin also has an enable bit, an unmask bit and two sticky status flags. One flag records detected interrupts and the other records wake events. Software clears either flag by writing 1 to it, so writing back a word it has just read clears whatever that word showed as set.

Pins are grouped in fours. Each group contributes one bit to a summary vector. The vector is split over two 32-bit words, so software can find the active pins quickly.

A single interrupt line goes high when any pin is deliverable. A pin is deliverable when its interrupt status is set while the pin is both enabled and unmasked, or when its wake status is set. Once high, the line stays high until software writes the end-of-interrupt bit in the master word. After that write the line drops for one cycle, and it rises again if anything is still deliverable.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: The word for pin n is at byte address 4n, with this bit layout:
  - [0] level mode (1 = level, 0 = edge)
  - [2:1] polarity
  - [3] enable
  - [4] unmask (1 = unmasked)
  - [5] wake status, write 1 to clear
  - [6] interrupt status, write 1 to clear
  - [7] pin level from the previous cycle, read-only

  Bits [4:0] read back as written. Every word reads zero after reset.
- R2: In edge mode the interrupt status sets on the clock edge after the pin is sampled with a changed level. Polarity 00 sets it on a falling change, 01 on a rising change, and 10 on either change.
- R3: Polarity 11 never sets status, in either mode. Polarity 10 in level mode never sets status either.
- R4: In level mode, polarity 00 sets status on every cycle the pin is low, and 01 on every cycle it is high. A clear write made while that level persists leaves the status set.
- R5: With enable at 0 the status never sets. The unmask bit does not affect status, only delivery.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. When a clear and a new detection fall in the same cycle, the status stays set.
- R7: A one-cycle pulse on a pin's wake input sets that pin's wake status. The wake status is deliverable whatever the enable and unmask bits are.
- R8: The word at byte 4*184 holds summary bits 0..31, and the word at byte 4*184+4 holds bits 32..45 in its bits [13:0]. All other bits of those words are zero. Summary bit k is set when either status flag of any of pins 4k..4k+3 is set, masked pins included.
- R9: When the line is low and some pin is deliverable, the line is high on the next cycle.
- R10: The master word is at byte 4*184+8. Writing it with bit 0 set drops the line on the next cycle. If a pin is still deliverable the line returns one cycle later. Without that write the line stays high, even after every status is cleared.
- R11: The master word and unmapped words read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl_i | input | NUM_GROUPS*GROUP_SIZE | Filtered pin levels |
| wake_evt_i | input | NUM_GROUPS*GROUP_SIZE | Per-pin wake event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | 32 | Read data, combinational from state |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its default 46 groups of four pins. At that size the last group lands in bit 13 of the second summary word, so the split of the summary across two words is exercised at its upper end. Pin 183 is driven directly to show that group-45 bit and the level-mode behaviour together. A behavioural model of all 184 pins is compared with the read port and the interrupt line on every clock. The comparison runs through directed sequences and through a long stretch of random configuration, clear, wake and end-of-interrupt traffic.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Bit positions inside a pin word
    localparam int BIT_LEVEL_MODE = 0;
    localparam int BIT_POL_LSB    = 1;
    localparam int BIT_ENABLE     = 3;
    localparam int BIT_UNMASK     = 4;
    localparam int BIT_WAKE_STS   = 5;
    localparam int BIT_IRQ_STS    = 6;
    localparam int BIT_PIN_LVL    = 7;
    localparam int CTRL_W         = 7;   // writable / clearable bits [6:0]
    localparam int WORD_W         = 32;

    typedef enum logic [1:0] {
        POL_LOW  = 2'b00,
        POL_HIGH = 2'b01,
        POL_BOTH = 2'b10,
        POL_RSVD = 2'b11
    } pol_e;

    typedef struct packed {
        logic level_mode;
        pol_e pol;
        logic en;
        logic unmask;
    } pin_cfg_t;

    typedef struct packed {
        pin_cfg_t cfg;
        logic     irq_sts;
        logic     wake_sts;
        logic     lvl;
    } pin_state_t;

    typedef struct packed {
        logic irq;
    } out_state_t;

endpackage

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_lvl_i,
    input  logic              wake_evt_i,
    input  logic              sel_wr_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] word_o,
    output logic              pending_o,
    output logic              deliver_o
);

    pin_state_t st_q, st_d;
    logic rise, fall, edge_hit, level_hit, detect, clr_irq, clr_wake;

    always_comb begin
        rise = pin_lvl_i & ~st_q.lvl;
        fall = ~pin_lvl_i & st_q.lvl;
        case (st_q.cfg.pol)
            POL_LOW:  begin edge_hit = fall;        level_hit = ~pin_lvl_i; end
            POL_HIGH: begin edge_hit = rise;        level_hit = pin_lvl_i;  end
            POL_BOTH: begin edge_hit = rise | fall; level_hit = 1'b0;       end
            default:  begin edge_hit = 1'b0;        level_hit = 1'b0;       end
        endcase
        detect   = st_q.cfg.en & (st_q.cfg.level_mode ? level_hit : edge_hit);
        clr_irq  = sel_wr_i & wr_data_i[BIT_IRQ_STS];
        clr_wake = sel_wr_i & wr_data_i[BIT_WAKE_STS];

        st_d          = st_q;
        st_d.lvl      = pin_lvl_i;
        st_d.irq_sts  = detect | (st_q.irq_sts & ~clr_irq);
        st_d.wake_sts = wake_evt_i | (st_q.wake_sts & ~clr_wake);
        if (sel_wr_i) begin
            st_d.cfg.level_mode = wr_data_i[BIT_LEVEL_MODE];
            st_d.cfg.pol        = pol_e'(wr_data_i[BIT_POL_LSB +: 2]);
            st_d.cfg.en         = wr_data_i[BIT_ENABLE];
            st_d.cfg.unmask     = wr_data_i[BIT_UNMASK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word_o = '0;
        word_o[BIT_LEVEL_MODE]    = st_q.cfg.level_mode;
        word_o[BIT_POL_LSB +: 2]  = st_q.cfg.pol;
        word_o[BIT_ENABLE]        = st_q.cfg.en;
        word_o[BIT_UNMASK]        = st_q.cfg.unmask;
        word_o[BIT_WAKE_STS]      = st_q.wake_sts;
        word_o[BIT_IRQ_STS]       = st_q.irq_sts;
        word_o[BIT_PIN_LVL]       = st_q.lvl;
    end

    assign pending_o = st_q.irq_sts | st_q.wake_sts;
    assign deliver_o = (st_q.irq_sts & st_q.cfg.en & st_q.cfg.unmask) | st_q.wake_sts;

    AST_DISABLED_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cfg.en && !st_q.irq_sts) |=> !st_q.irq_sts); // R5
    AST_RSVD_POL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.pol == POL_RSVD && !st_q.irq_sts) |=> !st_q.irq_sts); // R3
    AST_IRQ_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq_sts && !(sel_wr_i && wr_data_i[BIT_IRQ_STS])) |=> st_q.irq_sts); // R6
    AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt_i |=> st_q.wake_sts); // R7

endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
    parameter int NUM_GROUPS = 46,
    parameter int GROUP_SIZE = 4,
    parameter int SUM_W      = 64
) (
    input  logic [NUM_GROUPS*GROUP_SIZE-1:0] pending_i,
    input  logic [NUM_GROUPS*GROUP_SIZE-1:0] deliver_i,
    output logic [SUM_W-1:0]                 summary_o,
    output logic                             deliver_any_o
);

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_group
            assign summary_o[g] = |pending_i[g*GROUP_SIZE +: GROUP_SIZE];
        end
        if (SUM_W > NUM_GROUPS) begin : g_pad
            assign summary_o[SUM_W-1:NUM_GROUPS] = '0;
        end
    endgenerate

    assign deliver_any_o = |deliver_i;

endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator
    import gpio_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 46,
    parameter int GROUP_SIZE = 4,
    parameter int ADDR_W     = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_GROUPS*GROUP_SIZE-1:0] pin_lvl_i,
    input  logic [NUM_GROUPS*GROUP_SIZE-1:0] wake_evt_i,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                wr_addr_i,
    input  logic [31:0]                      wr_data_i,
    input  logic [ADDR_W-1:0]                rd_addr_i,
    output logic [31:0]                      rd_data_o,
    output logic                             irq_o
);

    localparam int NUM_PINS   = NUM_GROUPS * GROUP_SIZE;
    localparam int SUM_WORDS  = (NUM_GROUPS + 31) / 32;
    localparam int SUM_W      = 32 * SUM_WORDS;
    localparam int WIDX_W     = ADDR_W - 2;
    localparam int PIN_IDX_W  = $clog2(NUM_PINS);
    localparam logic [WIDX_W-1:0] PIN_LIMIT   = WIDX_W'(NUM_PINS);
    localparam logic [WIDX_W-1:0] SUM_BASE    = WIDX_W'(NUM_PINS);
    localparam logic [WIDX_W-1:0] MASTER_WORD = WIDX_W'(NUM_PINS + SUM_WORDS);

    logic [WIDX_W-1:0] wr_word, rd_word;
    logic [WORD_W-1:0] pin_word [NUM_PINS];
    logic [NUM_PINS-1:0] pending, deliver;
    logic [SUM_W-1:0]  summary;
    logic              deliver_any, eoi_wr;
    out_state_t        out_q, out_d;

    logic unused_bits;
    assign unused_bits = ^{wr_addr_i[1:0], rd_addr_i[1:0], wr_data_i[31:CTRL_W]};

    assign wr_word = wr_addr_i[ADDR_W-1:2];
    assign rd_word = rd_addr_i[ADDR_W-1:2];

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            gpio_irq_pin_cell u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .pin_lvl_i  (pin_lvl_i[p]),
                .wake_evt_i (wake_evt_i[p]),
                .sel_wr_i   (wr_en_i && (wr_word == WIDX_W'(p))),
                .wr_data_i  (wr_data_i[CTRL_W-1:0]),
                .word_o     (pin_word[p]),
                .pending_o  (pending[p]),
                .deliver_o  (deliver[p])
            );
        end
    endgenerate

    gpio_irq_summary #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_SIZE (GROUP_SIZE),
        .SUM_W      (SUM_W)
    ) u_summary (
        .pending_i     (pending),
        .deliver_i     (deliver),
        .summary_o     (summary),
        .deliver_any_o (deliver_any)
    );

    // Read multiplexer
    always_comb begin
        rd_data_o = '0;
        if (rd_word < PIN_LIMIT) begin
            rd_data_o = pin_word[rd_word[PIN_IDX_W-1:0]];
        end else begin
            for (int s = 0; s < SUM_WORDS; s++) begin
                if (rd_word == SUM_BASE + WIDX_W'(s)) rd_data_o = summary[32*s +: 32];
            end
        end
    end

    // Combined line: sticky until end-of-interrupt
    always_comb begin
        eoi_wr    = wr_en_i && (wr_word == MASTER_WORD) && wr_data_i[0];
        out_d     = out_q;
        out_d.irq = eoi_wr ? 1'b0 : (out_q.irq | deliver_any);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_o = out_q.irq;

    AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !eoi_wr) |=> irq_o); // R10
    AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> !irq_o); // R10
    AST_LINE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_any && !eoi_wr) |=> irq_o); // R9
    AST_DELIVER_IN_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_any |-> (summary != '0)); // R8

endmodule

// File: tb/gpio_irq_aggregator_tb.sv
`timescale 1ns/1ps
module gpio_irq_aggregator_tb_top;

    localparam int NG = 46;
    localparam int GS = 4;
    localparam int NP = NG * GS;
    localparam int AW = 12;
    localparam int SUM0_A   = NP * 4;
    localparam int SUM1_A   = NP * 4 + 4;
    localparam int MASTER_A = NP * 4 + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] pin_lvl = '0;
    logic [NP-1:0] wake_evt = '0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic irq;

    always #2 clk = ~clk;

    gpio_irq_aggregator #(.NUM_GROUPS(NG), .GROUP_SIZE(GS), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lvl_i(pin_lvl), .wake_evt_i(wake_evt),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    bit m_lm[NP]; bit [1:0] m_pol[NP]; bit m_en[NP]; bit m_un[NP];
    bit m_ist[NP]; bit m_wst[NP]; bit m_prev[NP]; bit m_irq;
    bit dany, eoi, sel, det, rise, fall, lv;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] model_read(int a);
        int w = a >> 2;
        bit [63:0] s = '0;
        if (w < NP)
            return {24'b0, m_prev[w], m_ist[w], m_wst[w], m_un[w], m_en[w], m_pol[w], m_lm[w]};
        for (int p = 0; p < NP; p++) if (m_ist[p] | m_wst[p]) s[p/GS] = 1'b1;
        if (w == NP) return s[31:0];
        if (w == NP + 1) return s[63:32];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_lm[p]=0; m_pol[p]=0; m_en[p]=0; m_un[p]=0; m_ist[p]=0; m_wst[p]=0; m_prev[p]=0;
            end
            m_irq = 0;
        end else begin
            dany = 0;
            for (int p = 0; p < NP; p++) dany |= (m_ist[p] & m_en[p] & m_un[p]) | m_wst[p];
            eoi = wr_en && (int'(wr_addr) == MASTER_A) && wr_data[0];
            for (int p = 0; p < NP; p++) begin
                sel = wr_en && (int'(wr_addr >> 2) == p);
                lv = pin_lvl[p];
                rise = lv && !m_prev[p];
                fall = !lv && m_prev[p];
                det = 0;
                if (m_en[p]) begin
                    if (m_lm[p]) det = (m_pol[p] == 2'd0) ? !lv : (m_pol[p] == 2'd1) ? lv : 1'b0;
                    else det = (m_pol[p] == 2'd0) ? fall : (m_pol[p] == 2'd1) ? rise :
                               (m_pol[p] == 2'd2) ? (rise || fall) : 1'b0;
                end
                m_ist[p] = det || (m_ist[p] && !(sel && wr_data[6]));
                m_wst[p] = wake_evt[p] || (m_wst[p] && !(sel && wr_data[5]));
                if (sel) begin
                    m_lm[p] = wr_data[0]; m_pol[p] = wr_data[2:1];
                    m_en[p] = wr_data[3]; m_un[p] = wr_data[4];
                end
                m_prev[p] = lv;
            end
            m_irq = eoi ? 1'b0 : (m_irq || dany);
        end
        #1;
        if (!done) begin
            check(cur_req, "model rd_data", rd_data, model_read(int'(rd_addr)));
            check(cur_req, "model irq", {31'b0, irq}, {31'b0, m_irq});
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_check(string tag, int a, logic [31:0] exp);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        check(tag, "read", rd_data, exp);
    endtask

    task automatic irq_check(string tag, logic exp);
        #1;
        check(tag, "irq line", {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // reset state
        cur_req = "R1";
        rd_check("R1", 0, 32'h0);
        rd_check("R1", 183*4, 32'h0);
        rd_check("R8", SUM0_A, 32'h0);
        rd_check("R11", MASTER_A, 32'h0);
        rd_check("R11", MASTER_A + 20, 32'h0);
        irq_check("R9", 0);
        // readback
        wr(5*4, 32'h7F);
        rd_check("R1", 5*4, 32'h1F);
        // reserved polarity and level-mode both
        cur_req = "R3";
        wr(6*4, 32'h1D);
        pin_lvl[5] = 1; pin_lvl[6] = 1; idle(2);
        rd_check("R3", 5*4, 32'h9F);
        rd_check("R3", 6*4, 32'h9D);
        pin_lvl[5] = 0; idle(2);
        rd_check("R3", 5*4, 32'h1F);
        irq_check("R3", 0);
        // rising edge
        cur_req = "R2";
        wr(0, 32'h1A);
        pin_lvl[0] = 1; idle(2);
        irq_check("R9", 1);
        rd_check("R2", 0, 32'hDA);
        rd_check("R8", SUM0_A, 32'h1);
        cur_req = "R6";
        wr(0, 32'h5A);
        rd_check("R6", 0, 32'h9A);
        irq_check("R10", 1);
        cur_req = "R10";
        wr(MASTER_A, 32'h1);
        irq_check("R10", 0);
        idle(1); irq_check("R10", 0);
        // falling edge
        cur_req = "R2";
        wr(4, 32'h18);
        pin_lvl[1] = 1; idle(2);
        rd_check("R2", 4, 32'h98);
        pin_lvl[1] = 0; idle(2);
        rd_check("R2", 4, 32'h58);
        irq_check("R9", 1);
        wr(4, 32'h58); wr(MASTER_A, 32'h1); idle(2);
        irq_check("R10", 0);
        // both edges
        wr(8, 32'h1C);
        pin_lvl[2] = 1; idle(1);
        rd_check("R2", 8, 32'hDC);
        wr(8, 32'h5C);
        rd_check("R6", 8, 32'h9C);
        pin_lvl[2] = 0; idle(1);
        rd_check("R2", 8, 32'h5C);
        wr(8, 32'h5C);
        rd_check("R6", 8, 32'h1C);
        wr(MASTER_A, 32'h1); idle(2);
        irq_check("R10", 0);
        // mask and enable
        cur_req = "R5";
        wr(32, 32'h0A);
        wr(40, 32'h12);
        pin_lvl[8] = 1; pin_lvl[10] = 1; idle(3);
        rd_check("R5", 32, 32'hCA);
        rd_check("R5", 40, 32'h92);
        irq_check("R5", 0);
        rd_check("R8", SUM0_A, 32'h4);
        wr(32, 32'h4A);
        rd_check("R8", SUM0_A, 32'h0);
        // level mode on the last pin
        cur_req = "R4";
        wr(183*4, 32'h1B);
        pin_lvl[183] = 1; idle(1);
        rd_check("R4", 183*4, 32'hDB);
        wr(183*4, 32'h5B);
        rd_check("R4", 183*4, 32'hDB);
        rd_check("R8", SUM1_A, 32'h2000);
        irq_check("R9", 1);
        pin_lvl[183] = 0; idle(1);
        wr(183*4, 32'h5B);
        rd_check("R4", 183*4, 32'h1B);
        rd_check("R8", SUM1_A, 32'h0);
        wr(MASTER_A, 32'h1); idle(2);
        irq_check("R10", 0);
        // wake
        cur_req = "R7";
        @(negedge clk); wake_evt[100] = 1;
        @(negedge clk); wake_evt[100] = 0;
        rd_check("R7", 400, 32'h20);
        rd_check("R8", SUM0_A, 32'h0200_0000);
        irq_check("R7", 1);
        wr(400, 32'h20);
        rd_check("R7", 400, 32'h0);
        wr(MASTER_A, 32'h1); idle(2);
        irq_check("R10", 0);
        // clear and detect in the same cycle
        cur_req = "R6";
        wr(12, 32'h1A);
        @(negedge clk);
        pin_lvl[3] = 1; wr_en = 1; wr_addr = AW'(12); wr_data = 32'h5A;
        @(negedge clk); wr_en = 0;
        rd_check("R6", 12, 32'hDA);
        idle(1);
        irq_check("R9", 1);
        // rearm with a pin still deliverable
        cur_req = "R10";
        wr(MASTER_A, 32'h1);
        irq_check("R10", 0);
        idle(1); irq_check("R10", 1);
        wr(12, 32'h5A); wr(MASTER_A, 32'h1); idle(2);
        irq_check("R10", 0);
        // random traffic compared against the model every clock
        cur_req = "R10";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                int p = (($urandom % 2) == 0) ? int'($urandom % 16) : 168 + int'($urandom % 16);
                if (($urandom % 4) == 0) pin_lvl[p] = ~pin_lvl[p];
            end
            wake_evt = '0;
            if (($urandom % 40) == 0) wake_evt[$urandom % NP] = 1'b1;
            wr_en = 0;
            case ($urandom % 10)
                0, 1: begin
                    int p = (($urandom % 2) == 0) ? int'($urandom % 16) : 168 + int'($urandom % 16);
                    wr_en = 1; wr_addr = AW'(p * 4); wr_data = $urandom & 32'h7F;
                end
                2: begin wr_en = 1; wr_addr = AW'(MASTER_A); wr_data = $urandom & 32'h1; end
                default: ;
            endcase
            case ($urandom % 4)
                0: rd_addr = AW'(SUM0_A);
                1: rd_addr = AW'(SUM1_A);
                2: rd_addr = AW'(($urandom % 16) * 4);
                default: rd_addr = AW'((168 + $urandom % 16) * 4);
            endcase
        end
        @(negedge clk);
        wr_en = 0; wake_evt = '0;
        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule